// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block turns a digital low-supply flag and a processor heartbeat into a system reset. An external comparator drives `supply_low`. While that flag is set, the block holds its reset outputs active. After the flag clears, the reset stays active for a programmed stretch. A processor toggles `wd_in` to show that it is still running. If the processor stops toggling for longer than the selected window, the block issues one full reset pulse. It also drops the `wd_ok` status flag, which stays low until the next accepted toggle.

All timing is counted in cycles of `tick`, a single-cycle enable taken from a prescaled timebase. `sel_ext` chooses the timebase:

- When it is high, the external-clock counts apply: 2048 ticks of reset, 4096 ticks for the first window after a reset, and 1024 ticks for later windows.
- When it is low, the internal-oscillator counts apply. These are parameters. `sel_short` picks the short or the long normal window in this mode. The first window after a reset is always the long one.

`wd_float` marks the heartbeat line as undriven, and it disables the watchdog.

The controller is one state machine with five named states:

| State | Meaning |
|-------|---------|
| `ST_LOW` | Supply is low |
| `ST_PULSE` | Reset is being stretched |
| `ST_ARM` | First watchdog window after a reset |
| `ST_RUN` | Normal watchdog window |
| `ST_OFF` | Watchdog disabled by a floating input |

Transitions between states:

- Any state goes to `ST_LOW` when `supply_low` is set.
- `ST_LOW` goes to `ST_PULSE` when `supply_low` clears.
- `ST_PULSE` goes to `ST_ARM` after the final reset tick.
- `ST_ARM` goes to `ST_RUN` on an accepted edge.
- `ST_ARM` and `ST_RUN` go to `ST_PULSE` on a timeout.
- `ST_RUN` stays in `ST_RUN` on an accepted edge, which restarts the window.
- `ST_ARM` and `ST_RUN` go to `ST_OFF` when `wd_float` is set.
- `ST_OFF` goes to `ST_ARM` when `wd_float` clears.

Top module: `wdog_supervisor`

## Requirements
- R1: While `supply_low` is 1, `rst_out_n` is 0, `rst_out` is 1 and `wd_ok` is 1 from the next clock on. `rst_out` is always the complement of `rst_out_n`.
- R2: After `supply_low` clears or the block reset is released, reset stays active for exactly N ticks. N is 2048 when `sel_ext`=1 and INT_RST_TICKS when `sel_ext`=0. Reset releases on the clock edge that samples the N-th tick.
- R3: The first watchdog window after any reset release lasts 4096 ticks when `sel_ext`=1 and INT_LONG_TICKS when `sel_ext`=0, whatever the value of `sel_short`.
- R4: After the first accepted edge, the window lasts 1024 ticks when `sel_ext`=1. When `sel_ext`=0 it lasts INT_SHORT_TICKS if `sel_short`=1 and INT_LONG_TICKS if `sel_short`=0.
- R5: A rising or a falling edge of `wd_in` is accepted after two synchronizing flops and restarts the window count. An edge wins over a tick that would expire the window in the same cycle.
- R6: On expiry, `wd_ok` goes to 0 in the same cycle that reset becomes active, and the reset lasts the full R2 length. `wd_ok` returns to 1 only on the next accepted edge.
- R7: With no toggling, reset pulses repeat, separated by one first-window period each.
- R8: While `wd_float` is 1, no watchdog reset occurs and `wd_ok` is 1. When `wd_float` clears, a fresh first window starts.
- R9: Edges of `wd_in` while reset is active are ignored. They neither raise `wd_ok` nor move the watchdog out of its first window.
- R10: Counts advance only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset; acts like a supply-low event |
| tick | input | 1 | One-cycle timebase enable |
| supply_low | input | 1 | Supply below threshold, from the comparator |
| wd_in | input | 1 | Processor heartbeat, asynchronous |
| wd_float | input | 1 | Heartbeat line undriven; disables the watchdog |
| sel_ext | input | 1 | 1 = external-clock counts, 0 = internal-oscillator counts |
| sel_short | input | 1 | Internal mode only: 1 = short normal window, 0 = long |
| rst_out_n | output | 1 | Active-low system reset |
| rst_out | output | 1 | Active-high system reset |
| wd_ok | output | 1 | Watchdog status; 0 after an expiry until the next edge |

## Verification
The bench tries the block with several heartbeat patterns:

- A quiet period inside the first long window shows whether the first window after reset is long or short.
- Regular toggling faster than the short window, with both edge directions, shows whether edges restart the count. Because a tick arrives every clock, these edges always coincide with ticks.
- A stop in toggling exposes the short expiry. Continued silence exposes the repeat interval of the pulses.
- Toggles placed inside a reset pulse show whether edges during reset are ignored.

A divided tick separates per-tick counting from per-clock counting. A floating heartbeat checks that the watchdog is disabled. A full external-count pass checks the 2048, 4096 and 1024 tick lengths.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_LOW,
        ST_PULSE,
        ST_ARM,
        ST_RUN,
        ST_OFF
    } sup_state_t;

    typedef enum logic [1:0] {
        WIN_RESET,
        WIN_FIRST,
        WIN_NORMAL
    } win_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    // sh[0..STAGES-1] synchronize; sh[STAGES] holds the previous synced value
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign edge_o = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/sup_window_sel.sv
module sup_window_sel
    import sup_pkg::*;
#(
    parameter int unsigned CW              = 13,
    parameter int unsigned EXT_RST_TICKS   = 2048,
    parameter int unsigned EXT_FIRST_TICKS = 4096,
    parameter int unsigned EXT_NORM_TICKS  = 1024,
    parameter int unsigned INT_RST_TICKS   = 200,
    parameter int unsigned INT_SHORT_TICKS = 100,
    parameter int unsigned INT_LONG_TICKS  = 1600
) (
    input  win_t          win,
    input  logic          sel_ext,
    input  logic          sel_short,
    output logic [CW-1:0] limit
);
    always_comb begin
        unique case (win)
            WIN_RESET:  limit = sel_ext ? CW'(EXT_RST_TICKS)   : CW'(INT_RST_TICKS);
            WIN_FIRST:  limit = sel_ext ? CW'(EXT_FIRST_TICKS) : CW'(INT_LONG_TICKS);
            WIN_NORMAL: limit = sel_ext ? CW'(EXT_NORM_TICKS)
                              : (sel_short ? CW'(INT_SHORT_TICKS) : CW'(INT_LONG_TICKS));
            default:    limit = CW'(INT_LONG_TICKS);
        endcase
    end
endmodule

// File: rtl/sup_tick_counter.sv
module sup_tick_counter #(
    parameter int unsigned CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + CW'(1);
    end

    assign hit = tick && (cnt == limit - CW'(1));

    // restart requested by the controller (edge, state change) empties the count
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // without a tick the count does not move
    assert_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned EXT_RST_TICKS   = 2048,
    parameter int unsigned EXT_FIRST_TICKS = 4096,
    parameter int unsigned EXT_NORM_TICKS  = 1024,
    parameter int unsigned INT_RST_TICKS   = 200,
    parameter int unsigned INT_SHORT_TICKS = 100,
    parameter int unsigned INT_LONG_TICKS  = 1600,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_low,
    input  logic wd_in,
    input  logic wd_float,
    input  logic sel_ext,
    input  logic sel_short,
    output logic rst_out_n,
    output logic rst_out,
    output logic wd_ok
);
    localparam int unsigned MAXV = max2(max2(max2(EXT_RST_TICKS, EXT_FIRST_TICKS),
                                             max2(EXT_NORM_TICKS, INT_RST_TICKS)),
                                        max2(INT_SHORT_TICKS, INT_LONG_TICKS));
    localparam int unsigned CW = $clog2(MAXV + 1);

    sup_state_t    state, nxt;
    win_t          win;
    logic [CW-1:0] limit;
    logic          hit, raw_edge, edge_acc, timeout, clr;

    sup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(wd_in), .edge_o(raw_edge)
    );

    sup_window_sel #(
        .CW(CW),
        .EXT_RST_TICKS(EXT_RST_TICKS), .EXT_FIRST_TICKS(EXT_FIRST_TICKS),
        .EXT_NORM_TICKS(EXT_NORM_TICKS), .INT_RST_TICKS(INT_RST_TICKS),
        .INT_SHORT_TICKS(INT_SHORT_TICKS), .INT_LONG_TICKS(INT_LONG_TICKS)
    ) u_win (
        .win(win), .sel_ext(sel_ext), .sel_short(sel_short), .limit(limit)
    );

    sup_tick_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .limit(limit), .hit(hit)
    );

    // next-state and control decode
    always_comb begin
        nxt      = state;
        edge_acc = 1'b0;
        timeout  = 1'b0;
        win      = WIN_FIRST;
        unique case (state)
            ST_LOW:   nxt = ST_PULSE;
            ST_PULSE: begin
                win = WIN_RESET;
                if (hit) nxt = ST_ARM;
            end
            ST_ARM, ST_RUN: begin
                win = (state == ST_RUN) ? WIN_NORMAL : WIN_FIRST;
                if (wd_float) begin
                    nxt = ST_OFF;
                end else if (raw_edge) begin
                    edge_acc = 1'b1;
                    nxt      = ST_RUN;
                end else if (hit) begin
                    timeout = 1'b1;
                    nxt     = ST_PULSE;
                end
            end
            ST_OFF:   if (!wd_float) nxt = ST_ARM;
            default:  nxt = ST_LOW;
        endcase
        if (supply_low) begin
            nxt      = ST_LOW;
            edge_acc = 1'b0;
            timeout  = 1'b0;
        end
        clr = (nxt != state) || edge_acc || (state == ST_LOW) || (state == ST_OFF);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOW;
        else        state <= nxt;
    end

    // status flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      wd_ok <= 1'b1;
        else if (supply_low || wd_float) wd_ok <= 1'b1;
        else if (timeout)                wd_ok <= 1'b0;
        else if (edge_acc)               wd_ok <= 1'b1;
    end

    // reset outputs decoded from state
    always_comb begin
        rst_out_n = !((state == ST_LOW) || (state == ST_PULSE));
        rst_out   = (state == ST_LOW) || (state == ST_PULSE);
    end

    assert_low_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (!rst_out_n && rst_out && wd_ok));

    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(tick));

    assert_ok_fall_with_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_ok) |-> $fell(rst_out_n));

    assert_float_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_float && !supply_low && rst_out_n) |=> (rst_out_n && wd_ok));

    assert_edge_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && !wd_ok && !supply_low && !wd_float) |=> !wd_ok);
endmodule

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;
    localparam int IR = 20, IS = 10, IL = 40;

    logic clk = 0, rst_n = 0, tick = 0, supply_low = 1, wd_in = 0, wd_float = 0;
    logic sel_ext = 0, sel_short = 1;
    logic rst_out_n, rst_out, wd_ok;

    int checks = 0, fails = 0, tper = 1, tc = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int ms = 0, mc = 0;
    bit mok = 1, h1 = 0, h2 = 0, h3 = 0;

    always #2 clk = ~clk;

    wdog_supervisor #(.INT_RST_TICKS(IR), .INT_SHORT_TICKS(IS), .INT_LONG_TICKS(IL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low), .wd_in(wd_in),
        .wd_float(wd_float), .sel_ext(sel_ext), .sel_short(sel_short),
        .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_ok(wd_ok)
    );

    always @(posedge clk) begin
        #1;
        if (tper <= 1) tick = 1;
        else begin tc++; tick = (tc % tper == 0); end
    end

    // behavioural model: 0 low, 1 reset stretch, 2 first window, 3 normal, 4 disabled
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mc = 0; mok = 1; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            bit e, hitm, to, acc;
            int lim, ns;
            e = (h2 != h3);
            h3 = h2; h2 = h1; h1 = wd_in;
            if (ms == 1)      lim = sel_ext ? 2048 : IR;
            else if (ms == 2) lim = sel_ext ? 4096 : IL;
            else              lim = sel_ext ? 1024 : (sel_short ? IS : IL);
            hitm = tick && (mc == lim - 1);
            ns = ms; to = 0; acc = 0;
            if (supply_low) ns = 0;
            else if (ms == 0) ns = 1;
            else if (ms == 1) begin if (hitm) ns = 2; end
            else if (ms == 2 || ms == 3) begin
                if (wd_float) ns = 4;
                else if (e) begin acc = 1; ns = 3; end
                else if (hitm) begin to = 1; ns = 1; end
            end else if (!wd_float) ns = 2;
            if (ns != ms || acc || ms == 0 || ms == 4) mc = 0;
            else if (tick) mc++;
            if (supply_low || wd_float) mok = 1;
            else if (to) mok = 0;
            else if (acc) mok = 1;
            ms = ns;
        end
    end

    always @(negedge clk) begin
        bit exp_rn;
        exp_rn = !(ms == 0 || ms == 1);
        checks++;
        if (rst_out_n !== exp_rn || rst_out !== !exp_rn || wd_ok !== mok) begin
            fails++;
            $display("FAIL %s t=%0t rst_n/rst/ok actual %b%b%b expected %b%b%b",
                     cur_req, $time, rst_out_n, rst_out, wd_ok, exp_rn, !exp_rn, mok);
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic toggles(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            wd_in = ~wd_in;
            wclk(gap);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired in phase %s", cur_req);
            finish_run();
        end
    end

    initial begin
        cur_req = "R1";       // reset state and supply-low hold
        wclk(5); rst_n = 1; wclk(10);
        cur_req = "R2";       // internal reset stretch
        supply_low = 0; wclk(25);
        cur_req = "R3";       // quiet past short window inside first long window
        wclk(30);
        cur_req = "R5";       // both edge directions, edges coincide with ticks
        toggles(8, 6);
        cur_req = "R4";       // short expiry
        wclk(15);
        cur_req = "R6";       // pulse with status low
        wclk(20);
        cur_req = "R7";       // repeated pulses without toggling
        wclk(150);
        cur_req = "R9";       // toggles during an active reset
        while (rst_out_n !== 1'b0) wclk(1);
        toggles(2, 3);
        while (rst_out_n !== 1'b1) wclk(1);
        wclk(45);
        cur_req = "R6";       // status recovers on edge
        toggles(1, 8);
        cur_req = "R4";       // long normal window
        supply_low = 1; sel_short = 0; wclk(5); supply_low = 0; wclk(22);
        toggles(5, 30); wclk(50);
        cur_req = "R10";      // divided tick
        tper = 3; toggles(5, 20); wclk(200); tper = 1;
        cur_req = "R8";       // floating heartbeat
        wd_float = 1; wclk(100); toggles(3, 10); wclk(100);
        wd_float = 0; wclk(60);
        cur_req = "R2";       // external counts
        supply_low = 1; sel_ext = 1; wclk(5); supply_low = 0; wclk(2100);
        cur_req = "R3";
        wclk(3000);
        cur_req = "R5";
        toggles(4, 800);
        cur_req = "R4";
        wclk(1100);
        cur_req = "R7";
        wclk(6300);
        done = 1;
        finish_run();
    end
endmodule